// File: doc/BRIEF.md
# Double-Buffer Display Base Controller

This block sits between the command stream of a framebuffer graphics engine and two consumers: the video scan-out side and the framebuffer pixel interface. Two base registers set where the display reads from and where rendering writes to. They deliberately follow different update rules. The scan-out base is staged and moves only at a frame boundary. The render offset takes hold the moment its register write arrives.

A write to the display start register goes into a staging copy and raises a swap-pending flag. Software may do this at any point in the frame. When the display timing side pulses end-of-vertical-blanking, the staged value becomes the active scan-out base and the flag drops. Software polls the flag and waits for it to clear before it points rendering at the buffer that was just shown. This prevents tearing.

Render coordinates arrive in screen space through a valid/ready port. The block forms `y * pitch + x` and adds the render offset as its very last step. It presents the linear pixel address one cycle later on a second valid/ready port. The line pitch is also register-programmed.

Top module: `dbuf_base_ctrl`

## Requirements
- R1: After reset, `scan_base` is 0, `swap_pending` is 0, `pix_valid` is 0, `crd_ready` is 1, and the pitch is the `RST_PITCH` parameter.
- R2: A write to address 0x3000 (display start) sets `swap_pending` in the next cycle and leaves `scan_base` unchanged while no `vblank_end` pulse occurs.
- R3: On a `vblank_end` cycle with a pending value, `scan_base` takes the staged value in the next cycle and `swap_pending` clears.
- R4: Several display start writes before one `vblank_end` leave only the last written value to be latched.
- R5: A display start write in the same cycle as `vblank_end` is latched at that boundary, and `swap_pending` is 0 afterwards.
- R6: A `vblank_end` pulse with nothing pending leaves `scan_base` unchanged.
- R7: Each accepted coordinate produces `pix_addr = (crd_y * pitch + crd_x + offset) mod 2^AW`, with `pix_valid` high in the cycle after the handshake and results kept in input order.
- R8: A write to address 0x3008 (render offset, low AW bits of data) applies to a coordinate accepted in the same cycle and to all later ones; earlier coordinates keep the old offset.
- R9: A write to address 0x3010 (line pitch, low PW bits of data) applies to a coordinate accepted in the same cycle and to all later ones.
- R10: While `pix_valid` is high and `pix_ready` is low, `pix_valid` and `pix_addr` hold. `crd_ready` is high exactly when the output stage is empty or being drained.
- R11: A write to any other address changes neither the staged or active display base nor the offset or pitch used for addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 16 | Register byte address |
| reg_wdata | input | AW | Register write data |
| vblank_end | input | 1 | One-cycle pulse at end of vertical blanking |
| scan_base | output | AW | Active scan-out start pixel |
| swap_pending | output | 1 | A display start write awaits the next frame boundary |
| crd_valid | input | 1 | Coordinate valid |
| crd_ready | output | 1 | Coordinate accepted when high with valid |
| crd_x | input | CW | Screen x |
| crd_y | input | CW | Screen y |
| pix_valid | output | 1 | Linear address valid |
| pix_ready | input | 1 | Downstream accepts address |
| pix_addr | output | AW | Linear pixel address |

## Verification
The bench builds the block with AW=20, CW=10, PW=12 and a reset pitch of 640. With a 20-bit address, an offset near 2^20 wraps the sum within a handful of coordinates, so the modulo rule of R7 is reached directly. The narrow widths keep the expected-address arithmetic in the scoreboard easy to restate. A pseudo-random `pix_ready` pattern exercises stalls, and offset or pitch writes are placed in the same cycle as a coordinate handshake.

// File: rtl/dbuf_pkg.sv
package dbuf_pkg;

  localparam int REG_AW = 16;

  localparam logic [REG_AW-1:0] ADR_DISP_START = 16'h3000;
  localparam logic [REG_AW-1:0] ADR_REND_OFF   = 16'h3008;
  localparam logic [REG_AW-1:0] ADR_LINE_PITCH = 16'h3010;

  typedef struct packed {
    logic disp;
    logic roff;
    logic pitch;
  } wr_sel_t;

  function automatic wr_sel_t decode_wr(input logic wr, input logic [REG_AW-1:0] a);
    wr_sel_t s;
    s.disp  = wr && (a == ADR_DISP_START);
    s.roff  = wr && (a == ADR_REND_OFF);
    s.pitch = wr && (a == ADR_LINE_PITCH);
    return s;
  endfunction

endpackage

// File: rtl/dbuf_reg_dec.sv
module dbuf_reg_dec #(
  parameter int AW        = 24,
  parameter int PW        = 14,
  parameter int RST_PITCH = 640
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr,
  input  logic [dbuf_pkg::REG_AW-1:0] addr,
  input  logic [AW-1:0]               wdata,
  input  logic [PW-1:0]               pitch_din,
  output dbuf_pkg::wr_sel_t           sel,
  output logic [AW-1:0]               roff_eff,
  output logic [PW-1:0]               pitch_eff
);
  logic [AW-1:0] roff_q;
  logic [PW-1:0] pitch_q;
  logic          wr_other;

  assign sel      = dbuf_pkg::decode_wr(wr, addr);
  assign wr_other = wr && !(sel.disp || sel.roff || sel.pitch);

  // a write arriving with a coordinate is already in force for it
  assign roff_eff  = sel.roff  ? wdata     : roff_q;
  assign pitch_eff = sel.pitch ? pitch_din : pitch_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      roff_q  <= '0;
      pitch_q <= PW'(RST_PITCH);
    end else begin
      if (sel.roff)  roff_q  <= wdata;
      if (sel.pitch) pitch_q <= pitch_din;
    end
  end

  p_roff_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sel.roff |=> roff_q == $past(wdata));

  p_pitch_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sel.pitch |=> pitch_q == $past(pitch_din));

  p_other_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_other |=> ($stable(roff_q) && $stable(pitch_q)));

endmodule

// File: rtl/dbuf_disp_latch.sv
module dbuf_disp_latch #(
  parameter int AW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_disp,
  input  logic [AW-1:0] wdata,
  input  logic          vblank_end,
  output logic [AW-1:0] scan_base,
  output logic          pending
);
  logic [AW-1:0] stage_q;
  logic [AW-1:0] scan_q;
  logic          pend_q;
  logic          latch_evt;
  logic [AW-1:0] latch_val;

  // frame boundary with something to take: a staged value or a write in flight
  assign latch_evt = vblank_end && (pend_q || wr_disp);
  assign latch_val = wr_disp ? wdata : stage_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage_q <= '0;
      scan_q  <= '0;
      pend_q  <= 1'b0;
    end else begin
      if (wr_disp) stage_q <= wdata;
      if (latch_evt) begin
        scan_q <= latch_val;
        pend_q <= 1'b0;
      end else if (wr_disp) begin
        pend_q <= 1'b1;
      end
    end
  end

  assign scan_base = scan_q;
  assign pending   = pend_q;

  p_hold_midframe_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !vblank_end |=> $stable(scan_q));

  p_pend_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_disp && !vblank_end) |=> pend_q);

  p_pend_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    vblank_end |=> !pend_q);

  p_take_staged_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (vblank_end && pend_q && !wr_disp) |=> scan_q == $past(stage_q));

  p_same_cycle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (vblank_end && wr_disp) |=> scan_q == $past(wdata));

  p_idle_boundary_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (vblank_end && !pend_q && !wr_disp) |=> $stable(scan_q));

endmodule

// File: rtl/dbuf_addr_pipe.sv
module dbuf_addr_pipe #(
  parameter int AW = 24,
  parameter int CW = 12,
  parameter int PW = 14
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          crd_valid,
  output logic          crd_ready,
  input  logic [CW-1:0] crd_x,
  input  logic [CW-1:0] crd_y,
  input  logic [PW-1:0] pitch,
  input  logic [AW-1:0] roff,
  output logic          pix_valid,
  input  logic          pix_ready,
  output logic [AW-1:0] pix_addr
);
  logic          vld_q;
  logic [AW-1:0] addr_q;
  logic          take;
  logic          stall;
  logic [AW-1:0] next_addr;

  // screen-space address first, offset added as the final step
  function automatic logic [AW-1:0] screen_lin(input logic [CW-1:0] x,
                                               input logic [CW-1:0] y,
                                               input logic [PW-1:0] p);
    logic [AW-1:0] row;
    row = AW'(y) * AW'(p);
    return row + AW'(x);
  endfunction

  function automatic logic [AW-1:0] rebase(input logic [AW-1:0] lin,
                                           input logic [AW-1:0] off);
    return lin + off;
  endfunction

  assign stall     = vld_q && !pix_ready;
  assign crd_ready = !stall;
  assign take      = crd_valid && crd_ready;
  assign next_addr = rebase(screen_lin(crd_x, crd_y, pitch), roff);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      addr_q <= '0;
    end else if (!stall) begin
      vld_q <= take;
      if (take) addr_q <= next_addr;
    end
  end

  assign pix_valid = vld_q;
  assign pix_addr  = addr_q;

  p_stall_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && !pix_ready) |=> (pix_valid && $stable(pix_addr)));

  p_accept_fills_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (crd_valid && crd_ready) |=> pix_valid);

  p_drain_empties_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && pix_ready && !crd_valid) |=> !pix_valid);

endmodule

// File: rtl/dbuf_base_ctrl.sv
module dbuf_base_ctrl #(
  parameter int AW        = 24,
  parameter int CW        = 12,
  parameter int PW        = 14,
  parameter int RST_PITCH = 640
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        reg_wr,
  input  logic [dbuf_pkg::REG_AW-1:0] reg_addr,
  input  logic [AW-1:0]               reg_wdata,
  input  logic                        vblank_end,
  output logic [AW-1:0]               scan_base,
  output logic                        swap_pending,
  input  logic                        crd_valid,
  output logic                        crd_ready,
  input  logic [CW-1:0]               crd_x,
  input  logic [CW-1:0]               crd_y,
  output logic                        pix_valid,
  input  logic                        pix_ready,
  output logic [AW-1:0]               pix_addr
);
  dbuf_pkg::wr_sel_t wr_sel;
  logic [AW-1:0]     roff_eff;
  logic [PW-1:0]     pitch_eff;

  dbuf_reg_dec #(.AW(AW), .PW(PW), .RST_PITCH(RST_PITCH)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr        (reg_wr),
    .addr      (reg_addr),
    .wdata     (reg_wdata),
    .pitch_din (reg_wdata[PW-1:0]),
    .sel       (wr_sel),
    .roff_eff  (roff_eff),
    .pitch_eff (pitch_eff)
  );

  dbuf_disp_latch #(.AW(AW)) u_disp (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_disp    (wr_sel.disp),
    .wdata      (reg_wdata),
    .vblank_end (vblank_end),
    .scan_base  (scan_base),
    .pending    (swap_pending)
  );

  dbuf_addr_pipe #(.AW(AW), .CW(CW), .PW(PW)) u_pipe (
    .clk       (clk),
    .rst_n     (rst_n),
    .crd_valid (crd_valid),
    .crd_ready (crd_ready),
    .crd_x     (crd_x),
    .crd_y     (crd_y),
    .pitch     (pitch_eff),
    .roff      (roff_eff),
    .pix_valid (pix_valid),
    .pix_ready (pix_ready),
    .pix_addr  (pix_addr)
  );

  p_rst_state_r1: assert property (@(posedge clk)
    !rst_n |=> (!swap_pending && !pix_valid && scan_base == '0));

endmodule

// File: tb/sim_dbuf_base_ctrl.sv
module sim_dbuf_base_ctrl;
  localparam int AW = 20;
  localparam int CW = 10;
  localparam int PW = 12;
  localparam int RSTP = 640;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reg_wr = 1'b0;
  logic [15:0]   reg_addr = '0;
  logic [AW-1:0] reg_wdata = '0;
  logic          vblank_end = 1'b0;
  logic [AW-1:0] scan_base;
  logic          swap_pending;
  logic          crd_valid = 1'b0;
  logic          crd_ready;
  logic [CW-1:0] crd_x = '0;
  logic [CW-1:0] crd_y = '0;
  logic          pix_valid;
  logic          pix_ready = 1'b1;
  logic [AW-1:0] pix_addr;

  always #10 clk = ~clk;

  dbuf_base_ctrl #(.AW(AW), .CW(CW), .PW(PW), .RST_PITCH(RSTP)) u0 (.*);

  int checks = 0;
  int errors = 0;
  bit done = 0;
  int rdy_mode = 0;
  logic [15:0] lfsr = 16'hACE1;

  logic [AW-1:0] m_scan = '0, m_stage = '0, m_roff = '0;
  int            m_pitch = RSTP;
  bit            m_pend = 0;
  logic [AW-1:0] expq[$];

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] exp_addr(input int x, input int y,
                                            input int p, input logic [AW-1:0] o);
    longint unsigned t;
    t = longint'(y) * longint'(p) + longint'(x) + longint'(o);
    return t[AW-1:0];
  endfunction

  // ready pattern, changed just after each edge
  always @(posedge clk) begin
    #1;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    pix_ready = (rdy_mode != 0) ? lfsr[0] : 1'b1;
  end

  // monitor / scoreboard
  bit            prev_stall = 0;
  logic [AW-1:0] prev_addr = '0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_stall) begin
        chk("R10 hold valid", pix_valid, 1);
        chk("R10 hold addr", pix_addr, prev_addr);
      end
      if (pix_valid && pix_ready) begin
        if (expq.size() == 0) chk("R7 unexpected output", 1, 0);
        else chk("R7 address", pix_addr, expq.pop_front());
      end
      prev_stall = pix_valid && !pix_ready;
      prev_addr  = pix_addr;
    end
  end

  task automatic apply_model(input logic [15:0] a, input logic [AW-1:0] d);
    if (a == 16'h3008) m_roff = d;
    else if (a == 16'h3010) m_pitch = int'(d[PW-1:0]);
    else if (a == 16'h3000) begin m_stage = d; m_pend = 1; end
  endtask

  task automatic wr_reg(input logic [15:0] a, input logic [AW-1:0] d);
    @(posedge clk); #2;
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #2;
    reg_wr = 0;
    apply_model(a, d);
  endtask

  task automatic vbl(input bit with_wr, input logic [AW-1:0] d);
    @(posedge clk); #2;
    vblank_end = 1;
    if (with_wr) begin reg_wr = 1; reg_addr = 16'h3000; reg_wdata = d; end
    @(posedge clk); #2;
    vblank_end = 0; reg_wr = 0;
    if (with_wr) begin m_scan = d; m_pend = 0; end
    else if (m_pend) begin m_scan = m_stage; m_pend = 0; end
  endtask

  task automatic chk_disp(input string req);
    @(negedge clk);
    chk({req, " scan_base"}, scan_base, m_scan);
    chk({req, " swap_pending"}, swap_pending, m_pend);
  endtask

  // coordinate send, optionally with a register write in its first cycle
  task automatic send(input int x, input int y, input bit with_wr,
                      input logic [15:0] a, input logic [AW-1:0] d);
    bit first = 1;
    bit acc = 0;
    @(posedge clk); #2;
    crd_valid = 1; crd_x = CW'(x); crd_y = CW'(y);
    if (with_wr) begin reg_wr = 1; reg_addr = a; reg_wdata = d; end
    while (!acc) begin
      @(negedge clk);
      if (crd_ready) begin
        logic [AW-1:0] o;
        int p;
        o = (first && with_wr && a == 16'h3008) ? d : m_roff;
        p = (first && with_wr && a == 16'h3010) ? int'(d[PW-1:0]) : m_pitch;
        expq.push_back(exp_addr(x, y, p, o));
        acc = 1;
      end
      @(posedge clk); #2;
      if (first && with_wr) begin reg_wr = 0; apply_model(a, d); end
      first = 0;
    end
    crd_valid = 0;
  endtask

  task automatic drain();
    int n = 0;
    while ((expq.size() != 0 || pix_valid) && n < 200) begin
      @(posedge clk); n++;
    end
    @(negedge clk);
    chk("R7 scoreboard drained", expq.size(), 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    @(negedge clk);
    chk("R1 scan_base", scan_base, 0);
    chk("R1 swap_pending", swap_pending, 0);
    chk("R1 pix_valid", pix_valid, 0);
    chk("R1 crd_ready", crd_ready, 1);
    // R1 reset pitch seen in an address
    send(3, 2, 0, 0, 0);
    drain();

    // R2 staged write holds scan-out
    wr_reg(16'h3000, 20'h12345);
    chk_disp("R2");
    repeat (5) @(posedge clk);
    chk_disp("R2 still");
    // R3 boundary latches
    vbl(0, 0);
    chk_disp("R3");
    // R6 idle boundary
    vbl(0, 0);
    chk_disp("R6");
    // R4 last write wins
    wr_reg(16'h3000, 20'h00A00);
    wr_reg(16'h3000, 20'h00B00);
    wr_reg(16'h3000, 20'h00C00);
    chk_disp("R4 pending");
    vbl(0, 0);
    chk_disp("R4");
    chk("R4 value", scan_base, 20'h00C00);
    // R5 write on the boundary cycle
    wr_reg(16'h3000, 20'h00111);
    vbl(1, 20'h00222);
    chk_disp("R5");
    chk("R5 value", scan_base, 20'h00222);

    // R7 several patterns, no backpressure
    send(0, 0, 0, 0, 0);
    send(639, 0, 0, 0, 0);
    send(5, 479, 0, 0, 0);
    wr_reg(16'h3008, 20'h4B000);
    send(1, 1, 0, 0, 0);
    // R7 wraparound of the sum
    wr_reg(16'h3008, 20'hFFFF0);
    send(20, 0, 0, 0, 0);
    send(0, 1, 0, 0, 0);
    drain();

    // R8 offset write together with a coordinate
    send(7, 3, 1, 16'h3008, 20'h01000);
    send(7, 3, 0, 0, 0);
    // R9 pitch write together with a coordinate
    send(2, 4, 1, 16'h3010, 20'h00100);
    send(2, 5, 0, 0, 0);
    drain();

    // R11 write elsewhere is ignored
    wr_reg(16'h3004, 20'hABCDE);
    wr_reg(16'h300C, 20'h55555);
    chk_disp("R11");
    send(9, 9, 0, 0, 0);
    vbl(0, 0);
    chk_disp("R11 after boundary");
    drain();

    // R10 random backpressure with a stream of coordinates
    rdy_mode = 1;
    for (int i = 0; i < 60; i++) begin
      if (i == 30) send(i, i + 1, 1, 16'h3008, 20'h00777);
      else send(i * 3, i, 0, 0, 0);
    end
    rdy_mode = 0;
    drain();

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule